// File: doc/BRIEF.md
# Timer Register Bridge Across Two Clock Domains

This block is an 8-bit timer/counter driven by a slow timer clock and programmed from a fast bus clock. Software writes three registers: the count, the compare value and the control word. Each write goes into a holding stage that belongs to that register alone. A toggle handshake then carries the value into the timer domain, where the destination register takes it on the second rising timer edge after the write. A busy bit for each register stays high in the bus domain until the acknowledge of that commit has come back through a two-flop synchronizer.

The counter has three operating states, chosen by the control register: `TS_STOP` (holds its value), `TS_NORM` (counts up and wraps from 255 to 0) and `TS_CTC` (counts up to the compare value and then clears). A compare match and an overflow each flip an event toggle in the timer domain. The bus domain synchronizes these toggles and turns them into sticky flags, which software clears by writing ones. A one-cycle wake pulse comes straight from the timer domain, so it still works when the bus clock is stopped.

Each holding stage runs a small state machine with two states, `HS_IDLE` and `HS_WAIT`. The transition `HS_IDLE -> HS_WAIT` takes place when a write to that register is accepted. The transition `HS_WAIT -> HS_IDLE` takes place when the synchronized acknowledge equals the request toggle. The counter state machine goes to `TS_STOP`, `TS_NORM` or `TS_CTC` whenever a control commit lands. Control bit 0 is run, bit 1 selects `TS_CTC` instead of `TS_NORM`, and bit 2 is the compare wake enable. The design assumes that the bus clock is more than four times faster than the timer clock.

Top module: `async_timer_bridge`

## Requirements
- R1: Addresses 0, 1 and 2 select the count, compare and control holding stages. Each stage holds its own value, so back-to-back writes to different registers all commit their own data.
- R2: A written value appears in its timer-domain register on the second rising timer edge after the bus edge that accepted the write. After the first timer edge the register still holds its old value.
- R3: The bit of `busy` for a register (bit 0 count, bit 1 compare, bit 2 control) reads 1 from the bus edge that accepts the write. It returns to 0 only after the commit acknowledge has passed two bus flops.
- R4: A write to a register whose busy bit is set is ignored. The pending value is not changed.
- R5: On the timer edge where a count or compare commit lands, a compare match produces neither a compare event nor a wake pulse. A clear in `TS_CTC` still takes place on that edge.
- R6: In `TS_CTC` the counter steps by one and goes to 0 on the tick after it equals the compare value. That tick also signals a compare match.
- R7: In `TS_NORM` the counter steps by one, wraps from 255 to 0 and signals an overflow on the wrap. A compare match in this state does not clear the counter.
- R8: Compare and overflow events set `cmp_flag` and `ovf_flag` in the bus domain. A write to address 3 with data bit 0 set clears `cmp_flag`, and with data bit 1 set clears `ovf_flag`. A new event in the same cycle takes precedence over the clear.
- R9: `wake` is high for the timer cycle after a non-suppressed compare match, provided that the wake enable (control bit 2) is set. With the enable clear it stays low.
- R10: After reset the count is 0, all busy bits are 0, both flags are 0 and `wake` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| tmr_clk | input | 1 | Slow asynchronous timer clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | 0 count, 1 compare, 2 control, 3 flag clear |
| wr_data | input | 8 | Write data |
| busy | output | 3 | Update-busy bits: count, compare, control |
| cmp_flag | output | 1 | Sticky compare flag, bus domain |
| ovf_flag | output | 1 | Sticky overflow flag, bus domain |
| wake | output | 1 | Compare wake pulse, timer domain |
| tmr_count | output | 8 | Current counter value, timer domain |

## Verification
The assertions check several behaviours on every cycle. They check that a commit loads exactly the held value, that a held value stays stable while its busy bit is set, and that a busy bit rises on an accepted write. They also check that a commit edge never produces a wake pulse, that the `TS_CTC` clear happens, and that the wrap in `TS_NORM` happens together with its overflow toggle. Other behaviours can only be shown by the bench's scenarios. These are the exact second-edge commit timing seen at the ports, the ignoring of a write while the register is busy, the independence of back-to-back writes, and the sticky flags with their write-one clear. Count sequences over many ticks, including randomly chosen compare values and start values, are also checked in the bench against a reference model.

// File: rtl/atb_pkg.sv
package atb_pkg;
    localparam int NREG = 3;

    typedef enum logic [1:0] {
        SEL_CNT = 2'd0,
        SEL_CMP = 2'd1,
        SEL_CTL = 2'd2,
        SEL_FLG = 2'd3
    } sel_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_WAIT = 1'b1
    } hold_st_e;

    typedef enum logic [1:0] {
        TS_STOP = 2'd0,
        TS_NORM = 2'd1,
        TS_CTC  = 2'd2
    } tmr_st_e;
endpackage

// File: rtl/atb_hold_chan.sv
module atb_hold_chan
    import atb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         bus_clk,
    input  logic         tmr_clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_val,
    output logic         busy,
    output logic         load,
    output logic [W-1:0] load_val
);
    hold_st_e     state_q, state_d;
    logic [W-1:0] hold_q;
    logic         req_tgl_q;
    logic         ack_s1_q, ack_s2_q;
    logic         rq_m_q, rq_s_q;
    logic         accept;

    assign accept = wr_hit && (state_q == HS_IDLE);

    // bus-side state register
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (wr_hit) state_d = HS_WAIT;
            HS_WAIT: if (ack_s2_q == req_tgl_q) state_d = HS_IDLE;
            default: state_d = HS_IDLE;
        endcase
    end

    // bus-side data path and acknowledge synchronizer
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            req_tgl_q <= 1'b0;
            ack_s1_q  <= 1'b0;
            ack_s2_q  <= 1'b0;
        end else begin
            if (accept) begin
                hold_q    <= wr_val;
                req_tgl_q <= ~req_tgl_q;
            end
            ack_s1_q <= rq_s_q;
            ack_s2_q <= ack_s1_q;
        end
    end

    assign busy = (state_q == HS_WAIT);

    // timer-side request synchronizer
    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_m_q <= 1'b0;
            rq_s_q <= 1'b0;
        end else begin
            rq_m_q <= req_tgl_q;
            rq_s_q <= rq_m_q;
        end
    end

    assign load     = rq_m_q ^ rq_s_q;
    assign load_val = hold_q;

    assert_hold_stable_R4: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (busy && wr_hit) |=> $stable(hold_q));

    assert_busy_set_R3: assert property (@(posedge bus_clk) disable iff (!rst_n)
        accept |=> busy);
endmodule

// File: rtl/atb_tmr_core.sv
module atb_tmr_core
    import atb_pkg::*;
#(
    parameter int W     = 8,
    parameter int CTL_W = 3
) (
    input  logic             tmr_clk,
    input  logic             rst_n,
    input  logic             ld_cnt,
    input  logic [W-1:0]     ld_cnt_val,
    input  logic             ld_cmp,
    input  logic [W-1:0]     ld_cmp_val,
    input  logic             ld_ctl,
    input  logic [CTL_W-1:0] ld_ctl_val,
    output logic [W-1:0]     count,
    output logic             cmp_tgl,
    output logic             ovf_tgl,
    output logic             wake
);
    localparam logic [W-1:0] CNT_MAX = '1;

    tmr_st_e      state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] cmp_q;
    logic         cie_q;
    logic         hit, suppress, cmp_evt, ovf_evt;

    assign suppress = ld_cnt || ld_cmp;
    assign hit      = (state_q != TS_STOP) && (cnt_q == cmp_q);
    assign cmp_evt  = hit && !suppress;
    assign ovf_evt  = (state_q == TS_NORM) && !ld_cnt && (cnt_q == CNT_MAX);

    // operating state register
    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ld_ctl) begin
            if (!ld_ctl_val[0])     state_d = TS_STOP;
            else if (ld_ctl_val[1]) state_d = TS_CTC;
            else                    state_d = TS_NORM;
        end
    end

    // next count per state
    always_comb begin
        cnt_d = cnt_q;
        if (ld_cnt) begin
            cnt_d = ld_cnt_val;
        end else begin
            unique case (state_q)
                TS_STOP: cnt_d = cnt_q;
                TS_NORM: cnt_d = cnt_q + 1'b1;
                TS_CTC:  cnt_d = hit ? '0 : cnt_q + 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge tmr_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_q   <= '0;
            cie_q   <= 1'b0;
            cmp_tgl <= 1'b0;
            ovf_tgl <= 1'b0;
            wake    <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (ld_cmp) cmp_q <= ld_cmp_val;
            if (ld_ctl) cie_q <= ld_ctl_val[2];
            if (cmp_evt) cmp_tgl <= ~cmp_tgl;
            if (ovf_evt) ovf_tgl <= ~ovf_tgl;
            wake <= cmp_evt && cie_q;
        end
    end

    assign count = cnt_q;

    assert_commit_count_R2: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        ld_cnt |=> (count == $past(ld_cnt_val)));

    assert_no_wake_on_commit_R5: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (ld_cnt || ld_cmp) |=> !wake);

    assert_ctc_clear_R6: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (state_q == TS_CTC && !ld_cnt && cnt_q == cmp_q) |=> (count == '0));

    assert_wrap_ovf_R7: assert property (@(posedge tmr_clk) disable iff (!rst_n)
        (state_q == TS_NORM && !ld_cnt && cnt_q == CNT_MAX)
            |=> (count == '0) && (ovf_tgl != $past(ovf_tgl)));
endmodule

// File: rtl/atb_flag_sync.sv
module atb_flag_sync (
    input  logic bus_clk,
    input  logic rst_n,
    input  logic evt_tgl,
    input  logic clr,
    output logic flag
);
    logic s1_q, s2_q, s3_q;
    logic set;

    assign set = s2_q ^ s3_q;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
            flag <= 1'b0;
        end else begin
            s1_q <= evt_tgl;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (set)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end

    assert_set_wins_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        set |=> flag);
endmodule

// File: rtl/async_timer_bridge.sv
module async_timer_bridge
    import atb_pkg::*;
#(
    parameter int W     = 8,
    parameter int CTL_W = 3
) (
    input  logic            bus_clk,
    input  logic            tmr_clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [W-1:0]    wr_data,
    output logic [NREG-1:0] busy,
    output logic            cmp_flag,
    output logic            ovf_flag,
    output logic            wake,
    output logic [W-1:0]    tmr_count
);
    logic             hit_cnt, hit_cmp, hit_ctl, hit_flg;
    logic             ld_cnt, ld_cmp, ld_ctl;
    logic [W-1:0]     cnt_val, cmp_val;
    logic [CTL_W-1:0] ctl_val;
    logic             cmp_tgl, ovf_tgl;

    assign hit_cnt = wr_en && (sel_e'(wr_addr) == SEL_CNT);
    assign hit_cmp = wr_en && (sel_e'(wr_addr) == SEL_CMP);
    assign hit_ctl = wr_en && (sel_e'(wr_addr) == SEL_CTL);
    assign hit_flg = wr_en && (sel_e'(wr_addr) == SEL_FLG);

    atb_hold_chan #(.W(W)) u_chan_cnt (
        .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr_hit(hit_cnt), .wr_val(wr_data),
        .busy(busy[0]), .load(ld_cnt), .load_val(cnt_val)
    );

    atb_hold_chan #(.W(W)) u_chan_cmp (
        .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr_hit(hit_cmp), .wr_val(wr_data),
        .busy(busy[1]), .load(ld_cmp), .load_val(cmp_val)
    );

    atb_hold_chan #(.W(CTL_W)) u_chan_ctl (
        .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr_hit(hit_ctl), .wr_val(wr_data[CTL_W-1:0]),
        .busy(busy[2]), .load(ld_ctl), .load_val(ctl_val)
    );

    atb_tmr_core #(.W(W), .CTL_W(CTL_W)) u_core (
        .tmr_clk(tmr_clk), .rst_n(rst_n),
        .ld_cnt(ld_cnt), .ld_cnt_val(cnt_val),
        .ld_cmp(ld_cmp), .ld_cmp_val(cmp_val),
        .ld_ctl(ld_ctl), .ld_ctl_val(ctl_val),
        .count(tmr_count), .cmp_tgl(cmp_tgl), .ovf_tgl(ovf_tgl), .wake(wake)
    );

    atb_flag_sync u_flag_cmp (
        .bus_clk(bus_clk), .rst_n(rst_n), .evt_tgl(cmp_tgl),
        .clr(hit_flg && wr_data[0]), .flag(cmp_flag)
    );

    atb_flag_sync u_flag_ovf (
        .bus_clk(bus_clk), .rst_n(rst_n), .evt_tgl(ovf_tgl),
        .clr(hit_flg && wr_data[1]), .flag(ovf_flag)
    );
endmodule

// File: tb/async_timer_bridge_bench.sv
module async_timer_bridge_bench;
    logic       bus_clk = 1'b0;
    logic       tmr_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] busy;
    logic       cmp_flag, ovf_flag, wake;
    logic [7:0] tmr_count;

    int checks = 0;
    int errors = 0;

    always #2  bus_clk = ~bus_clk;   // 250 MHz
    always #20 tmr_clk = ~tmr_clk;   // ratio 10, above the required four

    async_timer_bridge u_async_timer_bridge (
        .bus_clk(bus_clk), .tmr_clk(tmr_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .wake(wake), .tmr_count(tmr_count)
    );

    function automatic logic [7:0] next_cnt(logic [7:0] c, logic [7:0] top, bit ctc);
        if (ctc && c == top) return 8'd0;
        return c + 8'd1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy != 3'b000 && n < 400) begin
            @(negedge bus_clk);
            n++;
        end
        if (busy != 3'b000) chk("R3 idle timeout", {29'd0, busy}, 32'd0);
    endtask

    task automatic tmr_tick();
        @(posedge tmr_clk);
        #1;
    endtask

    task automatic set_ctl(logic [7:0] v);
        bus_write(2'd2, v);
        wait_idle();
    endtask

    // monitor n ticks against the model; cie tells if wake is expected
    task automatic watch(int n, logic [7:0] top, bit ctc, bit cie, string req);
        logic [7:0] prev;
        tmr_tick();
        prev = tmr_count;
        for (int i = 0; i < n; i++) begin
            tmr_tick();
            chk(req, tmr_count, next_cnt(prev, top, ctc));
            chk("R9 wake", wake, (cie && prev == top));
            prev = tmr_count;
        end
    endtask

    initial begin
        #3_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] top, start;
        bit cie;
        void'($urandom(32'd1234));
        repeat (5) @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge bus_clk);

        // R10 reset state
        chk("R10 count", tmr_count, 0);
        chk("R10 busy", busy, 0);
        chk("R10 flags", {cmp_flag, ovf_flag}, 0);
        chk("R10 wake", wake, 0);

        // R2 / R3 commit timing
        tmr_tick();
        bus_write(2'd0, 8'h2A);
        chk("R3 busy set", busy[0], 1);
        tmr_tick();
        chk("R2 first edge keeps old", tmr_count, 8'h00);
        tmr_tick();
        chk("R2 second edge commits", tmr_count, 8'h2A);
        chk("R3 busy held until ack", busy[0], 1);
        wait_idle();
        chk("R3 busy cleared", busy, 0);

        // R4 write while busy ignored
        tmr_tick();
        bus_write(2'd0, 8'h11);
        bus_write(2'd0, 8'h99);
        wait_idle();
        chk("R4 ignored write", tmr_count, 8'h11);

        // R1 independent holding stages
        tmr_tick();
        bus_write(2'd0, 8'h05);
        bus_write(2'd1, 8'h07);
        chk("R1 both busy", busy[1:0], 2'b11);
        wait_idle();
        chk("R1 count kept", tmr_count, 8'h05);

        // R6 / R9 CTC with wake enabled (top 7)
        set_ctl(8'b111);
        watch(24, 8'h07, 1'b1, 1'b1, "R6 ctc sequence");
        set_ctl(8'b000);
        repeat (4) tmr_tick();
        chk("R8 cmp flag set", cmp_flag, 1);
        bus_write(2'd3, 8'h01);
        chk("R8 cmp flag cleared", cmp_flag, 0);

        // R7 normal wrap and overflow flag, wake disabled
        bus_write(2'd0, 8'd250);
        wait_idle();
        set_ctl(8'b001);
        watch(12, 8'h07, 1'b0, 1'b0, "R7 normal sequence");
        set_ctl(8'b000);
        repeat (4) tmr_tick();
        chk("R7 ovf flag set", ovf_flag, 1);
        bus_write(2'd3, 8'h02);
        chk("R8 ovf flag cleared", ovf_flag, 0);

        // R5 suppression on a commit edge
        bus_write(2'd0, 8'd0);
        bus_write(2'd1, 8'd3);
        wait_idle();
        set_ctl(8'b111);
        begin
            int g = 0;
            do begin tmr_tick(); g++; end while (tmr_count != 8'd2 && g < 20);
        end
        bus_write(2'd1, 8'd3);
        tmr_tick();
        chk("R5 pre-match count", tmr_count, 8'd3);
        chk("R5 no wake yet", wake, 0);
        tmr_tick();
        chk("R5 ctc still clears", tmr_count, 8'd0);
        chk("R5 wake suppressed", wake, 0);
        repeat (4) tmr_tick();
        chk("R9 wake after next match", wake, 1);
        set_ctl(8'b000);

        // random CTC runs
        for (int k = 0; k < 6; k++) begin
            top   = 8'($urandom_range(15, 1));
            start = 8'($urandom_range(top, 0));
            cie   = 1'($urandom_range(1, 0));
            bus_write(2'd0, start);
            bus_write(2'd1, top);
            wait_idle();
            chk("R1 random count load", tmr_count, start);
            set_ctl({5'd0, cie, 2'b11});
            watch(30, top, 1'b1, cie, "R6 random ctc");
            set_ctl(8'b000);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule